// File: doc/BRIEF.md
# Ordered-Set Symbol Corruption Engine

This block sits in one direction of the ordered-set path of a multi-lane serial link. One symbol arrives per cycle. Each symbol is tagged with its lane, a start-of-set marker and a set-type code. The block repeats every symbol one cycle later. For a chosen ordered-set type on a chosen lane, it inverts one chosen symbol position in selected sets. This lets a receiver or a training state machine be tested against corrupted sets on purpose.

A 32-bit configuration word sets up a campaign. It holds the number of sets to corrupt and the spacing between the sets that are hit. It also holds gating conditions: the instance direction, the current training state and the current data rate. The training state and the data rate come in as plain inputs, and the block only compares against them. A 2-bit progress code is shown in a read-only status word for this instance's direction. The code reports idle, started, finished or failed.

Top module: `os_inj_engine`

## Requirements
- R1: Every input symbol appears at the output exactly one cycle later. This holds whether or not the symbol is corrupted. The output valid, start, type and lane copy the input of the previous cycle.
- R2: Set-type codes are TS0=0, TS1=1, TS2=2, CONTROL_SKIP=3, EIEOS=4, EIOS=5 and SDS=6. A CONTROL_SKIP set is 40 symbols long and every other type is 16 long. The symbol carrying the start marker has index 0, and indices are counted per lane.
- R3: Corruption is a bitwise inversion of the whole symbol. Only the symbol at the programmed index inside a targeted set is corrupted, and every other symbol passes unchanged.
- R4: A set is eligible only when all of the following agree with the configuration: enable is 1, the direction bit equals the instance direction (0 = transmit, 1 = receive), the set type matches, the lane matches, the training-state input matches and the rate input matches.
- R5: Eligible sets are numbered from 0 starting with the campaign. With spacing S, sets 0, S, 2S and so on are corrupted, up to the programmed count. A spacing of 0 behaves as 1.
- R6: The status code is 00 before the first corruption and 01 after it. It becomes 10 once the programmed count is reached. After 10, no further symbol is corrupted.
- R7: While enabled, the status becomes 11 and nothing is corrupted if either of these holds: the programmed index is at or beyond the length of the targeted type, or the count is 0.
- R8: The status becomes 11 if a start marker arrives on the programmed lane while the current set on that lane is still incomplete and the campaign is live. Code 11 holds until the configuration is written again.
- R9: Writing the configuration clears the set counters and sets the status to 00. A symbol that is in flight during the write cycle passes unchanged. Writing with enable 0 keeps the status at 00.
- R10: Register addresses are: 0 for configuration (read/write), 1 for transmit status and 2 for receive status. The code sits in bits [1:0]. The status word of the other direction reads 0, and writes to addresses 1 to 3 have no effect.
- R11: The configuration bit layout is: [0] enable, [1] direction, [4:2] rate, [8:5] count, [12:9] spacing, [15:13] set type, [21:16] training state, [25:22] lane, [31:26] symbol index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ltssm_i | input | 6 | Current training state |
| rate_i | input | 3 | Current data-rate code |
| in_valid_i | input | 1 | Input symbol valid |
| in_start_i | input | 1 | First symbol of a set |
| in_kind_i | input | 3 | Set type code |
| in_lane_i | input | LANE_W | Lane of the input symbol |
| in_sym_i | input | SYM_W | Input symbol |
| out_valid_o | output | 1 | Output symbol valid |
| out_start_o | output | 1 | Delayed start marker |
| out_kind_o | output | 3 | Delayed set type |
| out_lane_o | output | LANE_W | Delayed lane |
| out_sym_o | output | SYM_W | Output symbol, possibly inverted |

## Verification
A configuration write and the inversion of a target symbol can land in the same cycle. The bench sets this up by raising the write strobe exactly on the symbol that would be inverted. It expects that symbol to pass clean and the status to read 00 afterwards. It also expects the very next eligible set to be hit again, since the write resets the set numbering. A second collision is a premature start marker on the target lane, which meets the failure path while a campaign is live. That case is judged by the status sticking at 11 and by the following full set passing untouched.

// File: rtl/os_inj_pkg.sv
package os_inj_pkg;

  typedef enum logic [2:0] {
    OS_TS0   = 3'd0,
    OS_TS1   = 3'd1,
    OS_TS2   = 3'd2,
    OS_CSKIP = 3'd3,
    OS_EIEOS = 3'd4,
    OS_EIOS  = 3'd5,
    OS_SDS   = 3'd6
  } os_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_DONE = 2'b10,
    ST_FAIL = 2'b11
  } inj_stat_e;

  localparam int IDX_W    = 6;
  localparam int SHORT_OS = 16;
  localparam int LONG_OS  = 40;

  typedef struct packed {
    logic [IDX_W-1:0] sym_idx;  // [31:26]
    logic [3:0]       lane;     // [25:22]
    logic [5:0]       ltssm;    // [21:16]
    logic [2:0]       kind;     // [15:13]
    logic [3:0]       spacing;  // [12:9]
    logic [3:0]       count;    // [8:5]
    logic [2:0]       rate;     // [4:2]
    logic             dir;      // [1]
    logic             en;       // [0]
  } inj_cfg_t;

  function automatic logic [IDX_W-1:0] os_len(logic [2:0] kind);
    return (kind == 3'(OS_CSKIP)) ? IDX_W'(LONG_OS) : IDX_W'(SHORT_OS);
  endfunction

endpackage

// File: rtl/os_lane_tracker.sv
module os_lane_tracker
  import os_inj_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_v_i,
  input  logic             start_i,
  input  logic [2:0]       kind_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             in_set_o,
  output logic             short_o
);

  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] len_q;
  logic             active_q;

  assign idx_o    = start_i ? '0 : cnt_q;
  assign in_set_o = start_i | active_q;
  assign short_o  = start_i & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      len_q    <= '0;
      active_q <= 1'b0;
    end else if (sym_v_i) begin
      if (start_i) begin
        cnt_q    <= IDX_W'(1);
        len_q    <= os_len(kind_i);
        active_q <= 1'b1;
      end else if (active_q) begin
        cnt_q <= IDX_W'(cnt_q + 1'b1);
        if (IDX_W'(cnt_q + 1'b1) == len_q) active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/os_inject_ctrl.sv
module os_inject_ctrl
  import os_inj_pkg::*;
#(
  parameter bit IS_RX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  inj_cfg_t         cfg_i,
  input  logic             cfg_wr_i,
  input  logic             lane_hit_i,
  input  logic             start_i,
  input  logic [2:0]       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             in_set_i,
  input  logic             short_i,
  input  logic [5:0]       ltssm_i,
  input  logic [2:0]       rate_i,
  output logic             flip_o,
  output inj_stat_e        stat_o
);

  logic [3:0] hits_q, skip_q;
  logic       armed_q;
  inj_stat_e  stat_q;

  logic       en_ok, cfg_bad, running, set_match, hit_set;
  logic [3:0] gap;

  assign en_ok   = cfg_i.en && (cfg_i.dir == IS_RX) &&
                   (ltssm_i == cfg_i.ltssm) && (rate_i == cfg_i.rate);
  assign cfg_bad = cfg_i.en && (cfg_i.dir == IS_RX) &&
                   ((cfg_i.count == '0) || (cfg_i.sym_idx >= os_len(cfg_i.kind)));
  assign running = !cfg_bad && ((stat_q == ST_IDLE) || (stat_q == ST_BUSY));
  assign set_match = lane_hit_i && start_i && (kind_i == cfg_i.kind) && en_ok;
  assign hit_set = (set_match && (skip_q == '0)) ||
                   (armed_q && lane_hit_i && !start_i && in_set_i && en_ok);
  assign flip_o  = running && hit_set && (idx_i == cfg_i.sym_idx) && !cfg_wr_i;
  assign gap     = (cfg_i.spacing == '0) ? '0 : 4'(cfg_i.spacing - 1'b1);
  assign stat_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q  <= '0;
      skip_q  <= '0;
      armed_q <= 1'b0;
      stat_q  <= ST_IDLE;
    end else if (cfg_wr_i || !cfg_i.en) begin
      hits_q  <= '0;
      skip_q  <= '0;
      armed_q <= 1'b0;
      stat_q  <= ST_IDLE;
    end else if (cfg_bad) begin
      stat_q <= ST_FAIL;
    end else if (running && en_ok && lane_hit_i && short_i) begin
      stat_q  <= ST_FAIL;
      armed_q <= 1'b0;
    end else if (flip_o) begin
      hits_q  <= 4'(hits_q + 1'b1);
      skip_q  <= gap;
      armed_q <= 1'b0;
      stat_q  <= (4'(hits_q + 1'b1) == cfg_i.count) ? ST_DONE : ST_BUSY;
    end else if (lane_hit_i) begin
      if (start_i) begin
        armed_q <= set_match && (skip_q == '0);
        if (set_match && (skip_q != '0)) skip_q <= 4'(skip_q - 1'b1);
      end else if (!in_set_i) begin
        armed_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/os_inj_regs.sv
module os_inj_regs
  import os_inj_pkg::*;
#(
  parameter bit IS_RX = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  inj_stat_e   stat_i,
  output logic [31:0] rdata_o,
  output inj_cfg_t    cfg_o,
  output logic        cfg_wr_o
);

  logic [31:0] cfg_q;
  logic [31:0] stat_word;

  assign cfg_wr_o  = we_i && (addr_i == 2'd0);
  assign cfg_o     = inj_cfg_t'(cfg_q);
  assign stat_word = {30'b0, stat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_wr_o) cfg_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      2'd0:    rdata_o = cfg_q;
      2'd1:    rdata_o = IS_RX ? '0 : stat_word;
      2'd2:    rdata_o = IS_RX ? stat_word : '0;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/os_inj_engine.sv
module os_inj_engine
  import os_inj_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SYM_W     = 8,
  parameter bit IS_RX     = 1'b0,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [5:0]        ltssm_i,
  input  logic [2:0]        rate_i,
  input  logic              in_valid_i,
  input  logic              in_start_i,
  input  logic [2:0]        in_kind_i,
  input  logic [LANE_W-1:0] in_lane_i,
  input  logic [SYM_W-1:0]  in_sym_i,
  output logic              out_valid_o,
  output logic              out_start_o,
  output logic [2:0]        out_kind_o,
  output logic [LANE_W-1:0] out_lane_o,
  output logic [SYM_W-1:0]  out_sym_o
);

  inj_cfg_t  cfg;
  logic      cfg_wr;
  inj_stat_e stat;
  logic      flip;
  logic      lane_hit;

  logic [IDX_W-1:0] trk_idx    [NUM_LANES];
  logic             trk_in_set [NUM_LANES];
  logic             trk_short  [NUM_LANES];
  logic [IDX_W-1:0] sel_idx;
  logic             sel_in_set, sel_short;

  os_inj_regs #(.IS_RX(IS_RX)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .stat_i   (stat),
    .rdata_o  (reg_rdata_o),
    .cfg_o    (cfg),
    .cfg_wr_o (cfg_wr)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic sym_v;
    assign sym_v = in_valid_i && (32'(in_lane_i) == g);
    os_lane_tracker u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sym_v_i  (sym_v),
      .start_i  (in_start_i),
      .kind_i   (in_kind_i),
      .idx_o    (trk_idx[g]),
      .in_set_o (trk_in_set[g]),
      .short_o  (trk_short[g])
    );
  end

  always_comb begin
    sel_idx    = '0;
    sel_in_set = 1'b0;
    sel_short  = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (32'(in_lane_i) == i) begin
        sel_idx    = trk_idx[i];
        sel_in_set = trk_in_set[i];
        sel_short  = trk_short[i];
      end
    end
  end

  assign lane_hit = in_valid_i && (32'(in_lane_i) == 32'(cfg.lane));

  os_inject_ctrl #(.IS_RX(IS_RX)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .cfg_wr_i   (cfg_wr),
    .lane_hit_i (lane_hit),
    .start_i    (in_start_i),
    .kind_i     (in_kind_i),
    .idx_i      (sel_idx),
    .in_set_i   (sel_in_set),
    .short_i    (sel_short),
    .ltssm_i    (ltssm_i),
    .rate_i     (rate_i),
    .flip_o     (flip),
    .stat_o     (stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_start_o <= 1'b0;
      out_kind_o  <= '0;
      out_lane_o  <= '0;
      out_sym_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_start_o <= in_start_i;
      out_kind_o  <= in_kind_i;
      out_lane_o  <= in_lane_i;
      out_sym_o   <= in_sym_i ^ {SYM_W{flip}};
    end
  end

endmodule

// File: rtl/os_inj_engine_chk.sv
module os_inj_engine_chk #(
  parameter int SYM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             in_valid_i,
  input logic [SYM_W-1:0] in_sym_i,
  input logic             out_valid_o,
  input logic [SYM_W-1:0] out_sym_o,
  input logic             cfg_en,
  input logic [1:0]       stat
);

  logic live;
  logic cfg_wr;
  assign cfg_wr = reg_we_i && (reg_addr_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live <= 1'b0;
    else         live <= 1'b1;
  end

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    out_valid_o == $past(in_valid_i)); // R1
  AST_FLIP_IS_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    out_valid_o |-> (out_sym_o == $past(in_sym_i) || out_sym_o == ~$past(in_sym_i))); // R3
  AST_OFF_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    $past(!cfg_en) |-> out_sym_o == $past(in_sym_i)); // R4
  AST_DONE_NO_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    $past(stat == 2'b10) |-> out_sym_o == $past(in_sym_i)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == 2'b11 && !cfg_wr) |=> stat == 2'b11); // R8
  AST_WR_PASSES_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni || !live)
    $past(cfg_wr) |-> out_sym_o == $past(in_sym_i)); // R9
  AST_WR_CLEARS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> stat == 2'b00); // R9

endmodule

bind os_inj_engine os_inj_engine_chk #(.SYM_W(SYM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .in_valid_i  (in_valid_i),
  .in_sym_i    (in_sym_i),
  .out_valid_o (out_valid_o),
  .out_sym_o   (out_sym_o),
  .cfg_en      (cfg.en),
  .stat        (stat)
);

// File: tb/tb_os_inj_engine.sv
`timescale 1ns/1ps
module tb_os_inj_engine;
  localparam int NL = 4;
  localparam int SW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [5:0]    ltssm_i = 6'd9;
  logic [2:0]    rate_i = 3'd5;
  logic          in_valid_i = 1'b0;
  logic          in_start_i = 1'b0;
  logic [2:0]    in_kind_i = '0;
  logic [1:0]    in_lane_i = '0;
  logic [SW-1:0] in_sym_i = '0;
  logic          out_valid_o, out_start_o;
  logic [2:0]    out_kind_o;
  logic [1:0]    out_lane_o;
  logic [SW-1:0] out_sym_o;

  always #2.5 clk_i = ~clk_i;

  os_inj_engine #(.NUM_LANES(NL), .SYM_W(SW), .IS_RX(1'b0)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ltssm_i(ltssm_i),
    .rate_i(rate_i), .in_valid_i(in_valid_i), .in_start_i(in_start_i),
    .in_kind_i(in_kind_i), .in_lane_i(in_lane_i), .in_sym_i(in_sym_i),
    .out_valid_o(out_valid_o), .out_start_o(out_start_o), .out_kind_o(out_kind_o),
    .out_lane_o(out_lane_o), .out_sym_o(out_sym_o)
  );

  int nvec = 0, nerr = 0;
  bit done = 0;
  int c_count = 0, c_sp = 0, c_idx = 0;

  function automatic logic [31:0] mkcfg(bit en, bit dir, int rate, int cnt, int sp,
                                        int kind, int st, int lane, int idx);
    return {6'(idx), 4'(lane), 6'(st), 3'(kind), 4'(sp), 4'(cnt), 3'(rate), dir, en};
  endfunction

  function automatic int set_len(int kind);
    return (kind == 3) ? 40 : 16;
  endfunction

  function automatic bit exp_flip(int ord, int sidx);
    int sp = (c_sp == 0) ? 1 : c_sp;
    return (sidx == c_idx) && (ord % sp == 0) && (ord / sp < c_count);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    in_valid_i = 1'b0;
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic step_sym(int lane, bit st, int kind, bit expf, string req,
                          bit wr = 1'b0, logic [31:0] wv = '0);
    logic [SW-1:0] d, e;
    d = SW'($urandom);
    e = expf ? ~d : d;
    in_valid_i = 1'b1; in_start_i = st; in_kind_i = 3'(kind); in_lane_i = 2'(lane);
    in_sym_i = d; reg_we_i = wr; reg_addr_i = 2'd0; reg_wdata_i = wv;
    @(posedge clk_i); @(negedge clk_i);
    in_valid_i = 1'b0; reg_we_i = 1'b0;
    check(out_valid_o === 1'b1 && out_sym_o === e, req, {23'b0, out_valid_o, out_sym_o},
          {23'b0, 1'b1, e});
  endtask

  task automatic send_set(int lane, int kind, int ord, string req,
                          int wr_at = -1, logic [31:0] wv = '0);
    for (int i = 0; i < set_len(kind); i++)
      step_sym(lane, i == 0, kind,
               ord >= 0 && (wr_at < 0 || i < wr_at) && exp_flip(ord, i),
               req, i == wr_at, wv);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] v);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
    idle(1);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    reg_addr_i = a;
    #0.5;
    check(reg_rdata_o === exp, req, reg_rdata_o, exp);
  endtask

  task automatic campaign(int cnt, int sp, int kind, int lane, int idx);
    c_count = cnt; c_sp = sp; c_idx = idx;
    wr(2'd0, mkcfg(1'b1, 1'b0, 5, cnt, sp, kind, 9, lane, idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] cv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    check(out_valid_o === 1'b0, "R1 reset valid", {31'b0, out_valid_o}, 32'd0);
    rd(2'd0, 32'd0, "R11 reset cfg");
    rd(2'd1, 32'd0, "R6 reset status");

    // disabled: everything passes, latency one cycle
    c_count = 0;
    send_set(0, 1, -1, "R1");
    send_set(2, 3, -1, "R3");

    // spacing 8, count 2 on TS1 lane 2 index 5; sets beyond the count stay clean
    campaign(2, 8, 1, 2, 5);
    rd(2'd0, mkcfg(1'b1, 1'b0, 5, 2, 8, 1, 9, 2, 5), "R11 cfg readback");
    send_set(2, 1, 0, "R5 first hit");
    rd(2'd1, 32'd1, "R6 started");
    for (int k = 1; k < 17; k++) begin
      send_set(2, 1, k, "R5 spacing");
      if (k == 4) begin
        send_set(2, 2, -1, "R4 other type");
        send_set(1, 1, -1, "R4 other lane");
      end
    end
    rd(2'd1, 32'd2, "R6 completed");

    // long set: last symbol of CONTROL_SKIP
    campaign(1, 0, 3, 0, 39);
    send_set(0, 3, 0, "R2 index 39");
    rd(2'd1, 32'd2, "R2 long set done");

    // invalid configurations
    campaign(1, 0, 3, 0, 40);
    rd(2'd1, 32'd3, "R7 index past long set");
    c_count = 0;
    send_set(0, 3, -1, "R7 no flip when failed");
    campaign(1, 0, 0, 1, 16);
    rd(2'd1, 32'd3, "R7 index past short set");
    campaign(0, 0, 1, 1, 2);
    rd(2'd1, 32'd3, "R7 zero count");

    // gating conditions
    c_count = 0;
    wr(2'd0, mkcfg(1'b1, 1'b1, 5, 1, 0, 1, 9, 2, 5));
    send_set(2, 1, -1, "R4 direction");
    rd(2'd1, 32'd0, "R4 direction status");
    campaign(1, 0, 1, 2, 5);
    c_count = 0;
    ltssm_i = 6'd3;
    send_set(2, 1, -1, "R4 state mismatch");
    ltssm_i = 6'd9; rate_i = 3'd1;
    send_set(2, 1, -1, "R4 rate mismatch");
    rate_i = 3'd5;
    rd(2'd1, 32'd0, "R4 mismatch status");
    c_count = 1;
    send_set(2, 1, 0, "R4 all agree");

    // short set
    campaign(3, 0, 1, 1, 10);
    for (int i = 0; i < 5; i++) step_sym(1, i == 0, 1, 1'b0, "R8 partial");
    c_count = 0;
    send_set(1, 1, -1, "R8 early start");
    rd(2'd1, 32'd3, "R8 failure code");
    send_set(1, 1, -1, "R8 sticky no flip");
    rd(2'd1, 32'd3, "R8 sticky");

    // abort by write
    campaign(3, 2, 2, 0, 3);
    rd(2'd1, 32'd0, "R9 write clears fail");
    send_set(0, 2, 0, "R9 pre-abort hit");
    rd(2'd1, 32'd1, "R9 running");
    cv = mkcfg(1'b1, 1'b0, 5, 3, 2, 2, 9, 0, 3);
    wr(2'd0, cv);
    rd(2'd1, 32'd0, "R9 abort status");
    send_set(0, 2, 0, "R9 restart hit");
    wr(2'd0, cv);
    send_set(0, 2, 0, "R9 write same cycle", 3, cv);
    send_set(0, 2, 0, "R9 after collide");
    wr(2'd0, mkcfg(1'b0, 1'b0, 5, 3, 2, 2, 9, 0, 3));
    rd(2'd1, 32'd0, "R9 disabled");

    // register map
    campaign(1, 0, 4, 3, 0);
    send_set(3, 4, 0, "R3 index 0");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'd2, "R10 status read-only");
    rd(2'd2, 32'd0, "R10 other direction");
    wr(2'd3, 32'h1234_5678);
    rd(2'd0, mkcfg(1'b1, 1'b0, 5, 1, 0, 4, 9, 3, 0), "R10 cfg unchanged");

    // random campaigns
    for (int c = 0; c < 8; c++) begin
      automatic int k  = $urandom_range(6, 0);
      automatic int ln = $urandom_range(3, 0);
      automatic int ix = $urandom_range(set_len(k) - 1, 0);
      automatic int cn = $urandom_range(4, 1);
      automatic int sp = $urandom_range(4, 0);
      automatic int ns = $urandom_range(14, 8);
      automatic int nm = 0;
      automatic int spe, hits;
      campaign(cn, sp, k, ln, ix);
      for (int s = 0; s < ns; s++) begin
        if ($urandom_range(9, 0) < 7) begin
          send_set(ln, k, nm, "R5 random");
          nm++;
        end else begin
          automatic int ol = $urandom_range(3, 0);
          automatic int ok = $urandom_range(6, 0);
          if (ol == ln && ok == k) ok = (k + 1) % 7;
          send_set(ol, ok, -1, "R3 random other");
        end
      end
      spe  = (sp == 0) ? 1 : sp;
      hits = (nm + spe - 1) / spe;
      if (hits > cn) hits = cn;
      rd(2'd1, (hits == cn) ? 32'd2 : ((hits > 0) ? 32'd1 : 32'd0), "R6 random status");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule